// File: doc/BRIEF.md
# Pulse-Toggled Serial Mode Selector

This block decides whether a serial link runs in command mode or in data-throughput mode. A host controller drives an active-low control line that idles high. Each time the host holds the line low for a pulse of roughly the agreed length and then releases it, the block flips the link to the other mode. Pulses that are too short count as glitches and pulses that are too long are rejected. Neither kind changes anything.

The raw line first passes through a synchroniser. The block then counts how many clock ticks the synchronised line stays low. On the rising edge that ends the pulse, it compares that count with a window of plus or minus one quarter around a nominal tick count that software programs. A pulse inside the window toggles the mode flag. In the same cycle the flag changes, a one-cycle change strobe fires so that the serial transmitter and receiver can react.

Top module: `pulse_mode_sel`

## Requirements
- R1: In the first cycle after reset is released, `thru_mode` is 0 (command mode; 1 means throughput mode) and `mode_chg` is 0.
- R2: A qualified low pulse seen while in command mode sets `thru_mode` to 1.
- R3: A qualified low pulse seen while in throughput mode returns `thru_mode` to 0, so every qualified pulse toggles the mode.
- R4: A pulse qualifies when its length L, counted as the number of rising clock edges at which `ctl_raw_n` is sampled low, satisfies lo <= L <= hi. Here tol = floor(`nominal_ticks`/4), lo = `nominal_ticks` - tol and hi = `nominal_ticks` + tol. Both bounds are inclusive.
- R5: A pulse with L < lo, including a single-cycle glitch, leaves `thru_mode` unchanged and raises no strobe.
- R6: A pulse with L > hi leaves `thru_mode` unchanged. A pulse with L >= 2^CNT_W - 1 (the internal counter saturates) also never qualifies, even when hi is larger.
- R7: The toggle is taken only when the line rises. `thru_mode` changes at the third rising clock edge at which `ctl_raw_n` is sampled high after the pulse, and never while the line is still low.
- R8: `mode_chg` is high for exactly the one cycle in which `thru_mode` holds its new value for the first time, and it is low in every other cycle.
- R9: `nominal_ticks` may be reprogrammed while the line is idle high. The next pulse is judged against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_raw_n | input | 1 | Raw active-low control line from the host, asynchronous |
| nominal_ticks | input | CNT_W | Nominal qualifying pulse length in clock ticks |
| thru_mode | output | 1 | Current mode: 0 command, 1 throughput |
| mode_chg | output | 1 | One-cycle strobe on every mode change |

## Verification
The assertions assume that `ctl_raw_n` changes cleanly between clock edges. Under that assumption the synchronised pulse length equals the sampled raw low count that the checker measures on its own. They also assume that `nominal_ticks` stays stable while a pulse is in flight, so that the window the checker applies at the strobe is the one the design used. The stimulus drives the line only on falling clock edges and changes the nominal count only after the line has been high long enough for the pipeline to drain. Random pulse lengths span half to twice the nominal value, so the glitch, in-window and over-long cases all occur. Directed pulses sit on each window bound and on the counter's saturation point.

// File: rtl/pulse_mode_sel_pkg.sv
package pulse_mode_sel_pkg;
   typedef enum logic {
      LINK_CMD  = 1'b0,
      LINK_THRU = 1'b1
   } link_mode_e;

   function automatic link_mode_e flip_mode(input link_mode_e m);
      return (m == LINK_CMD) ? LINK_THRU : LINK_CMD;
   endfunction
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   initial begin
      if (STAGES < 2) $error("pms_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= IDLE_VAL;
               else     chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= IDLE_VAL;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pms_low_meter.sv
module pms_low_meter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             line_s,
   output logic             rise,
   output logic [CNT_W-1:0] low_len,
   output logic             low_sat
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             line_q;
   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q  <= 1'b1;
         run_cnt <= '0;
      end else begin
         line_q <= line_s;
         if (line_s)                run_cnt <= '0;
         else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
      end
   end

   assign rise    = line_s & ~line_q;
   assign low_len = run_cnt;
   assign low_sat = (run_cnt == CNT_MAX);
endmodule

// File: rtl/pms_window.sv
module pms_window #(
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned TOL_SHIFT = 2
) (
   input  logic [CNT_W-1:0] nominal,
   input  logic [CNT_W-1:0] len,
   input  logic             sat,
   output logic             hit
);
   localparam int unsigned EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] nom_x, tol_x, lo_x, hi_x, len_x;

   always_comb begin
      nom_x = {1'b0, nominal};
      len_x = {1'b0, len};
      tol_x = nom_x >> TOL_SHIFT;
      lo_x  = nom_x - tol_x;
      hi_x  = nom_x + tol_x;
      hit   = !sat && (len_x >= lo_x) && (len_x <= hi_x);
   end
endmodule

// File: rtl/pulse_mode_sel.sv
module pulse_mode_sel
   import pulse_mode_sel_pkg::*;
#(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned TOL_SHIFT   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ctl_raw_n,
   input  logic [CNT_W-1:0] nominal_ticks,
   output logic             thru_mode,
   output logic             mode_chg
);
   initial begin
      if (CNT_W < 3)            $error("pulse_mode_sel: CNT_W must be at least 3");
      if (TOL_SHIFT >= CNT_W)   $error("pulse_mode_sel: TOL_SHIFT must be below CNT_W");
      if (SYNC_STAGES < 2)      $error("pulse_mode_sel: SYNC_STAGES must be at least 2");
   end

   logic             line_s;
   logic             rise;
   logic             low_sat;
   logic             hit;
   logic [CNT_W-1:0] low_len;
   link_mode_e       mode_q;
   logic             chg_q;

   pms_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (ctl_raw_n),
      .dout (line_s)
   );

   pms_low_meter #(.CNT_W(CNT_W)) u_meter (
      .clk     (clk),
      .rst     (rst),
      .line_s  (line_s),
      .rise    (rise),
      .low_len (low_len),
      .low_sat (low_sat)
   );

   pms_window #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT)) u_win (
      .nominal (nominal_ticks),
      .len     (low_len),
      .sat     (low_sat),
      .hit     (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= LINK_CMD;
         chg_q  <= 1'b0;
      end else begin
         chg_q <= rise && hit;
         if (rise && hit) mode_q <= flip_mode(mode_q);
      end
   end

   assign thru_mode = (mode_q == LINK_THRU);
   assign mode_chg  = chg_q;
endmodule

// File: rtl/pulse_mode_sel_chk.sv
module pulse_mode_sel_chk #(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned TOL_SHIFT   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             ctl_raw_n,
   input logic [CNT_W-1:0] nominal_ticks,
   input logic             thru_mode,
   input logic             mode_chg
);
   localparam int unsigned LW = CNT_W + 2;
   localparam logic [LW-1:0] LMAX = {LW{1'b1}};
   localparam logic [LW-1:0] SATV = {2'b00, {CNT_W{1'b1}}};

   logic          rst_q = 1'b1;
   logic          raw_q = 1'b1;
   logic [LW-1:0] run_len = '0;
   logic [LW-1:0] last_len = '0;
   logic [LW-1:0] tol, lo, hi;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      raw_q <= ctl_raw_n;
      if (ctl_raw_n) begin
         run_len <= '0;
         if (!raw_q) last_len <= run_len;
      end else if (run_len != LMAX) begin
         run_len <= run_len + 1'b1;
      end
   end

   always_comb begin
      tol = {2'b00, nominal_ticks} >> TOL_SHIFT;
      lo  = {2'b00, nominal_ticks} - tol;
      hi  = {2'b00, nominal_ticks} + tol;
   end

   // R1: state right after reset release
   always_ff @(posedge clk) begin
      if (rst_q && !rst) begin
         assert_reset_state_R1: assert (!thru_mode && !mode_chg)
            else $error("R1 reset state wrong");
      end
   end

   // R8: strobe marks exactly the cycles where the flag changed
   assert_strobe_matches_flip_R8: assert property (@(posedge clk) disable iff (rst)
      mode_chg == (thru_mode != $past(thru_mode)));

   // R8: strobe never lasts two cycles
   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
      mode_chg |=> !mode_chg);

   // R4/R5/R6: a change only follows a pulse inside the window and below saturation
   assert_window_hit_R4: assert property (@(posedge clk) disable iff (rst)
      mode_chg |-> (last_len >= lo && last_len <= hi && last_len < SATV));

   generate
      if (SYNC_STAGES == 2) begin : g_lat2
         // R7: change lands on the third high sample after a low one
         assert_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
            mode_chg |-> ($past(ctl_raw_n, 2) && $past(ctl_raw_n, 3) && !$past(ctl_raw_n, 4)));
      end
   endgenerate
endmodule

bind pulse_mode_sel pulse_mode_sel_chk #(
   .CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .ctl_raw_n     (ctl_raw_n),
   .nominal_ticks (nominal_ticks),
   .thru_mode     (thru_mode),
   .mode_chg      (mode_chg)
);

// File: tb/test_pulse_mode_sel.sv
`timescale 1ns/1ps
module test_pulse_mode_sel;
   localparam int unsigned CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             ctl_raw_n = 1'b1;
   logic [CNT_W-1:0] nominal_ticks = 8'd40;
   logic             thru_mode;
   logic             mode_chg;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  exp_mode = 1'b0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   pulse_mode_sel #(.CNT_W(CNT_W)) i_pulse_mode_sel (
      .clk           (clk),
      .rst           (rst),
      .ctl_raw_n     (ctl_raw_n),
      .nominal_ticks (nominal_ticks),
      .thru_mode     (thru_mode),
      .mode_chg      (mode_chg)
   );

   function automatic bit qualifies(input int len, input int nom);
      int tol;
      tol = nom / 4;
      if (len >= (1 << CNT_W) - 1) return 1'b0;
      return (len >= nom - tol) && (len <= nom + tol);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // drive a low pulse of len sampled cycles, then check timing of the result
   task automatic pulse(input int len, input string req);
      bit q;
      bit old;
      q   = qualifies(len, int'(nominal_ticks));
      old = exp_mode;
      @(negedge clk) ctl_raw_n = 1'b0;
      repeat (len) @(negedge clk);
      ctl_raw_n = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      check({req, " R7 no early change"}, int'(thru_mode), int'(old));
      check({req, " R7 no early strobe"}, int'(mode_chg), 0);
      @(posedge clk); #1;
      if (q) exp_mode = ~exp_mode;
      check({req, " mode"}, int'(thru_mode), int'(exp_mode));
      check({req, " R8 strobe"}, int'(mode_chg), int'(q));
      @(posedge clk); #1;
      check({req, " R8 strobe drop"}, int'(mode_chg), 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (6) @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      check("R1 mode", int'(thru_mode), 0);
      check("R1 strobe", int'(mode_chg), 0);

      // nominal 40: tol 10, window 30..50
      nominal_ticks = 8'd40;
      pulse(40, "R2 nominal to thru");
      pulse(40, "R3 nominal back to cmd");
      pulse(1,  "R5 glitch");
      pulse(29, "R5 just short");
      pulse(30, "R4 lower bound");
      pulse(50, "R4 upper bound");
      pulse(51, "R6 just long");
      pulse(120, "R6 very long");

      // R9: new nominal 100 -> window 75..125
      nominal_ticks = 8'd100;
      pulse(50, "R9 old-window len rejected");
      pulse(75, "R9 new lower bound");
      pulse(125, "R9 new upper bound");

      // nominal 220: window 165..275, counter saturates at 255
      nominal_ticks = 8'd220;
      pulse(254, "R6 below saturation");
      pulse(255, "R6 saturated");
      pulse(300, "R6 beyond saturation");

      // nominal 3: tol 0, window 3..3
      nominal_ticks = 8'd3;
      pulse(2, "R5 tiny window short");
      pulse(3, "R4 tiny window exact");
      pulse(4, "R6 tiny window long");

      for (int i = 0; i < 80; i++) begin
         int nom;
         int len;
         nom = 20 + int'($urandom_range(0, 40));
         nominal_ticks = CNT_W'(nom);
         len = int'($urandom_range(nom / 2, nom * 2));
         pulse(len, "R4 random");
         repeat (int'($urandom_range(0, 5))) @(negedge clk);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule